// File: doc/BRIEF.md
# Set-Associative Tag Directory with Miss Classification

This block models the tag side of a small set-associative cache. It holds no data. Each request carries a byte address. The block looks the address up in its tag array, installs the block on a miss, and updates the per-set least-recently-used (LRU) state. It also reports why the access missed, using a three-way classification: first reference, conflict or capacity.

The block keeps two extra structures for the classification. The first is a history bit per block number, which records whether that block has been referenced since reset. The second is a fully associative shadow directory with LRU order, whose capacity in blocks equals that of the real cache.

The default configuration has 2 sets of 2 ways with 8-byte blocks and 8-bit addresses. All results are registered, so they appear one cycle after the request strobe. A new request can be presented on every cycle. The per-way valid bits, the stored tags and the LRU pointers are brought out for inspection.

Top module: `tag_miss_classifier`

## Requirements
- R1: A request address is split into byte offset = bits [2:0], set index = bit [3] and tag = bits [7:4]. These three fields are returned on the response. For example, 0xF7 gives tag 0xF, set 0 and offset 7.
- R2: Synchronous reset empties the cache. It clears every valid bit, every stored tag, every LRU pointer, the block history and the shadow directory, so the first access after reset to any block is a first-reference miss.
- R3: Each request produces exactly one response, with `rsp_valid` high on the cycle after the request. Requests may be issued back to back. A cycle without a request produces no response and leaves all exposed state unchanged.
- R4: An access hits when a valid way of the indexed set holds the request tag. The result code is 00 and `rsp_way` is the matching way.
- R5: On a miss the block is installed in the indexed set. The target is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the LRU way. The target way becomes valid with the request tag, and `rsp_way` names it.
- R6: After any access, hit or miss, the LRU pointer of the accessed set names the way that was not accessed.
- R7: A miss on a block number (address bits [7:3]) that has not been referenced since reset has result code 01. Every access marks its block as referenced.
- R8: A miss on a block that has been referenced before has result code 10 when the block is present in the shadow directory as it stood before this access.
- R9: Any other miss has result code 11.
- R10: The shadow directory is fully associative and holds as many blocks as the cache (4 by default), kept in recency order. Every access, hit or miss, makes its block the most recent entry. A block that is not present evicts the least recent entry.
- R11: `way_valid` bit s*2+w and `way_tag` bits [(s*2+w)*4 +: 4] show the valid bit and the tag of way w in set s. Bit s of `lru_way` is the LRU way of set s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 8 | Request byte address |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_tag | output | 4 | Tag field of the request |
| rsp_index | output | 1 | Set index of the request |
| rsp_offset | output | 3 | Byte offset of the request |
| rsp_result | output | 2 | 00 hit, 01 first reference, 10 conflict, 11 capacity |
| rsp_way | output | 1 | Way that hit or was filled |
| lru_way | output | 2 | Per-set LRU way |
| way_valid | output | 4 | Per-way valid bits, set-major |
| way_tag | output | 16 | Per-way tags, set-major, 4 bits each |

## Verification
The assertions assume that reset is held for at least one clock edge before the first request. They also assume that `req_addr` is a known value whenever `req_valid` is high, so that the history bit and the shadow lookup are well defined. The bench raises reset at time zero and again mid-run, and drives every input on the falling edge from known values. Its stimulus covers a full ascending sweep of all 256 addresses and long pseudo-random runs over a narrowed pool of blocks, with idle cycles interleaved. The narrowed pool ensures that all four result codes occur.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

  typedef enum logic [1:0] {
    RES_HIT      = 2'b00,
    RES_COLD     = 2'b01,
    RES_CONFLICT = 2'b10,
    RES_CAPACITY = 2'b11
  } result_e;

  // Outcome ordering: a hit wins, then first reference, then shadow presence.
  function automatic result_e classify(input logic hit, input logic seen, input logic in_shadow);
    if (hit)            return RES_HIT;
    else if (!seen)     return RES_COLD;
    else if (in_shadow) return RES_CONFLICT;
    else                return RES_CAPACITY;
  endfunction

endpackage

// File: rtl/tmc_tag_store.sv
module tmc_tag_store #(
  parameter int IDX_W = 1,
  parameter int TAG_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        acc_en,
  input  logic [IDX_W-1:0]            acc_idx,
  input  logic [TAG_W-1:0]            acc_tag,
  output logic                        hit,
  output logic                        acc_way,
  output logic [(1<<IDX_W)-1:0]       lru_q,
  output logic [(1<<IDX_W)*2-1:0]     valid_q,
  output logic [(1<<IDX_W)*2*TAG_W-1:0] tag_q
);
  localparam int SETS = 1 << IDX_W;
  localparam int WAYS = 2;

  logic [WAYS-1:0] match;
  logic [WAYS-1:0] set_valid;
  logic            victim;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w] = valid_q[int'(acc_idx) * WAYS + w];
      match[w]     = set_valid[w] &&
                     (tag_q[(int'(acc_idx) * WAYS + w) * TAG_W +: TAG_W] == acc_tag);
    end
  end

  assign hit = |match;

  // Invalid ways are filled lowest first, before the LRU way is evicted.
  always_comb begin
    if (!set_valid[0])      victim = 1'b0;
    else if (!set_valid[1]) victim = 1'b1;
    else                    victim = lru_q[acc_idx];
  end

  assign acc_way = hit ? match[1] : victim;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0]       v_r;
    logic [WAYS*TAG_W-1:0] t_r;
    logic                  l_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_r <= '0;
        t_r <= '0;
        l_r <= 1'b0;
      end else if (acc_en && (int'(acc_idx) == s)) begin
        v_r[acc_way]                <= 1'b1;
        t_r[acc_way*TAG_W +: TAG_W] <= acc_tag;
        l_r                         <= ~acc_way;
      end
    end

    assign valid_q[s*WAYS +: WAYS]             = v_r;
    assign tag_q[s*WAYS*TAG_W +: WAYS*TAG_W]   = t_r;
    assign lru_q[s]                            = l_r;
  end

endmodule

// File: rtl/tmc_seen_history.sv
module tmc_seen_history #(
  parameter int BLK_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic [BLK_W-1:0] acc_blk,
  output logic             seen
);
  localparam int NBLK = 1 << BLK_W;

  logic [NBLK-1:0] seen_r;

  assign seen = seen_r[acc_blk];

  always_ff @(posedge clk) begin
    if (rst)         seen_r <= '0;
    else if (acc_en) seen_r[acc_blk] <= 1'b1;
  end

endmodule

// File: rtl/tmc_shadow_dir.sv
module tmc_shadow_dir #(
  parameter int BLK_W   = 5,
  parameter int ENTRIES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic [BLK_W-1:0] acc_blk,
  output logic             hit
);
  // Entry 0 is most recent; invalid entries always sit at the tail.
  logic [ENTRIES-1:0] ent_v;
  logic [BLK_W-1:0]   ent_b [ENTRIES];
  int                 hit_pos;

  always_comb begin
    hit     = 1'b0;
    hit_pos = ENTRIES - 1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_v[i] && ent_b[i] == acc_blk) begin
        hit     = 1'b1;
        hit_pos = i;
      end
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_v[i] <= 1'b0;
        ent_b[i] <= '0;
      end else if (acc_en) begin
        if (i == 0) begin
          ent_v[i] <= 1'b1;
          ent_b[i] <= acc_blk;
        end else if (i <= hit_pos) begin
          ent_v[i] <= ent_v[(i > 0) ? i - 1 : 0];
          ent_b[i] <= ent_b[(i > 0) ? i - 1 : 0];
        end
      end
    end
  end

endmodule

// File: rtl/tag_miss_classifier.sv
module tag_miss_classifier #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 1
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       req_valid,
  input  logic [ADDR_W-1:0]                          req_addr,
  output logic                                       rsp_valid,
  output logic [ADDR_W-IDX_W-OFF_W-1:0]              rsp_tag,
  output logic [IDX_W-1:0]                           rsp_index,
  output logic [OFF_W-1:0]                           rsp_offset,
  output logic [1:0]                                 rsp_result,
  output logic                                       rsp_way,
  output logic [(1<<IDX_W)-1:0]                      lru_way,
  output logic [(1<<IDX_W)*2-1:0]                    way_valid,
  output logic [(1<<IDX_W)*2*(ADDR_W-IDX_W-OFF_W)-1:0] way_tag
);
  import tmc_pkg::*;

  localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W    = ADDR_W - OFF_W;
  localparam int SETS     = 1 << IDX_W;
  localparam int WAYS     = 2;
  localparam int SHADOW_N = SETS * WAYS;

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [OFF_W-1:0] addr_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [BLK_W-1:0] addr_blk(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: BLK_W];
  endfunction

  // Named internal events, visible to the bound checker.
  logic    lookup_hit;
  logic    seen_before;
  logic    shadow_hit;
  logic    acc_way;
  result_e outcome;

  tmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk     (clk),
    .rst     (rst),
    .acc_en  (req_valid),
    .acc_idx (addr_idx(req_addr)),
    .acc_tag (addr_tag(req_addr)),
    .hit     (lookup_hit),
    .acc_way (acc_way),
    .lru_q   (lru_way),
    .valid_q (way_valid),
    .tag_q   (way_tag)
  );

  tmc_seen_history #(.BLK_W(BLK_W)) hist_i (
    .clk     (clk),
    .rst     (rst),
    .acc_en  (req_valid),
    .acc_blk (addr_blk(req_addr)),
    .seen    (seen_before)
  );

  tmc_shadow_dir #(.BLK_W(BLK_W), .ENTRIES(SHADOW_N)) shadow_i (
    .clk     (clk),
    .rst     (rst),
    .acc_en  (req_valid),
    .acc_blk (addr_blk(req_addr)),
    .hit     (shadow_hit)
  );

  assign outcome = classify(lookup_hit, seen_before, shadow_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_tag    <= '0;
      rsp_index  <= '0;
      rsp_offset <= '0;
      rsp_result <= 2'b00;
      rsp_way    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_tag    <= addr_tag(req_addr);
        rsp_index  <= addr_idx(req_addr);
        rsp_offset <= addr_off(req_addr);
        rsp_result <= outcome;
        rsp_way    <= acc_way;
      end
    end
  end

endmodule

// File: rtl/tag_miss_classifier_chk.sv
module tag_miss_classifier_chk #(
  parameter int IDX_W = 1,
  parameter int TAG_W = 4
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            req_valid,
  input logic                            rsp_valid,
  input logic [TAG_W-1:0]                rsp_tag,
  input logic [IDX_W-1:0]                rsp_index,
  input logic                            rsp_way,
  input logic [(1<<IDX_W)-1:0]           lru_way,
  input logic [(1<<IDX_W)*2-1:0]         way_valid,
  input logic [(1<<IDX_W)*2*TAG_W-1:0]   way_tag,
  input logic                            lookup_hit,
  input logic                            seen_before,
  input logic                            shadow_hit
);
  logic             filled_v;
  logic [TAG_W-1:0] filled_t;

  always_comb begin
    filled_v = way_valid[int'(rsp_index) * 2 + int'(rsp_way)];
    filled_t = way_tag[(int'(rsp_index) * 2 + int'(rsp_way)) * TAG_W +: TAG_W];
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R3
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R3
  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(way_valid) && $stable(way_tag) && $stable(lru_way))); // R3
  AST_HIT_IMPLIES_SEEN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lookup_hit) |-> seen_before); // R7
  AST_UNSEEN_NOT_SHADOWED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !seen_before) |-> !shadow_hit); // R8
  AST_LRU_POINTS_AWAY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (lru_way[rsp_index] != rsp_way)); // R6
  AST_FILLED_RESIDENT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (filled_v && filled_t == rsp_tag)); // R5
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((way_valid & $past(way_valid)) == $past(way_valid))); // R5

endmodule

bind tag_miss_classifier tag_miss_classifier_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .rsp_valid   (rsp_valid),
  .rsp_tag     (rsp_tag),
  .rsp_index   (rsp_index),
  .rsp_way     (rsp_way),
  .lru_way     (lru_way),
  .way_valid   (way_valid),
  .way_tag     (way_tag),
  .lookup_hit  (lookup_hit),
  .seen_before (seen_before),
  .shadow_hit  (shadow_hit)
);

// File: tb/tag_miss_classifier_tb.sv
module tag_miss_classifier_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [7:0]  req_addr;
  logic        rsp_valid;
  logic [3:0]  rsp_tag;
  logic [0:0]  rsp_index;
  logic [2:0]  rsp_offset;
  logic [1:0]  rsp_result;
  logic        rsp_way;
  logic [1:0]  lru_way;
  logic [3:0]  way_valid;
  logic [15:0] way_tag;

  int total = 0;
  int bad   = 0;
  int class_cnt [4];
  bit finished = 0;

  // Bench-side model state
  bit       mv [2][2];
  bit [3:0] mt [2][2];
  bit       ml [2];
  bit       seen [32];
  bit       shv [4];
  bit [4:0] shb [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_miss_classifier dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_index(rsp_index),
    .rsp_offset(rsp_offset), .rsp_result(rsp_result), .rsp_way(rsp_way),
    .lru_way(lru_way), .way_valid(way_valid), .way_tag(way_tag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit [3:0] exp_valid();
    return {mv[1][1], mv[1][0], mv[0][1], mv[0][0]};
  endfunction

  function automatic bit [15:0] exp_tags();
    return {mt[1][1], mt[1][0], mt[0][1], mt[0][0]};
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 2; s++) begin
      ml[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 0; mt[s][w] = 0; end
    end
    for (int b = 0; b < 32; b++) seen[b] = 0;
    for (int i = 0; i < 4; i++) begin shv[i] = 0; shb[i] = 0; end
  endtask

  task automatic check_state(input string req);
    check(lru_way == {ml[1], ml[0]}, {req, " lru"}, lru_way, {ml[1], ml[0]});
    check(way_valid == exp_valid(), {req, " valid"}, way_valid, exp_valid());
    check(way_tag == exp_tags(), {req, " tags"}, way_tag, exp_tags());
  endtask

  task automatic do_reset();
    rst = 1; req_valid = 0; req_addr = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    model_clear();
    check(rsp_valid == 0, "R2 reset rsp_valid", rsp_valid, 0);
    check_state("R2 reset");
  endtask

  task automatic access(input bit [7:0] a);
    bit       s;
    bit [3:0] tg;
    bit [4:0] blk;
    bit       h0, h1, sh;
    int       p;
    int       res;
    bit       way;
    s = a[3]; tg = a[7:4]; blk = a[7:3];
    h0 = mv[s][0] && mt[s][0] == tg;
    h1 = mv[s][1] && mt[s][1] == tg;
    sh = 0; p = 3;
    for (int i = 0; i < 4; i++) if (shv[i] && shb[i] == blk) begin sh = 1; p = i; end
    if (h0 || h1) begin
      res = 0; way = h1;
    end else begin
      way = !mv[s][0] ? 1'b0 : (!mv[s][1] ? 1'b1 : ml[s]);
      res = !seen[blk] ? 1 : (sh ? 2 : 3);
    end
    mv[s][way] = 1; mt[s][way] = tg; ml[s] = ~way; seen[blk] = 1;
    // R10 recency order update in the model
    for (int i = p; i > 0; i--) begin shv[i] = shv[i-1]; shb[i] = shb[i-1]; end
    shv[0] = 1; shb[0] = blk;

    req_valid = 1; req_addr = a;
    @(negedge clk);
    check(rsp_valid == 1, "R3 response strobe", rsp_valid, 1);
    check({rsp_tag, rsp_index, rsp_offset} == a, "R1 field split",
          {rsp_tag, rsp_index, rsp_offset}, a);
    case (res)
      0: check(rsp_result == 2'b00, "R4 hit code", rsp_result, 0);
      1: check(rsp_result == 2'b01, "R7 first reference code", rsp_result, 1);
      2: check(rsp_result == 2'b10, "R8/R10 conflict code", rsp_result, 2);
      default: check(rsp_result == 2'b11, "R9/R10 capacity code", rsp_result, 3);
    endcase
    class_cnt[res]++;
    check(rsp_way == way, res == 0 ? "R4 hit way" : "R5 fill way", rsp_way, way);
    check(lru_way == {ml[1], ml[0]}, "R6 lru after access", lru_way, {ml[1], ml[0]});
    check(way_valid == exp_valid(), "R11 valid vector", way_valid, exp_valid());
    check(way_tag == exp_tags(), "R11 tag vector", way_tag, exp_tags());
    req_valid = 0;
  endtask

  task automatic idle();
    req_valid = 0;
    req_addr  = 8'hA5;
    @(negedge clk);
    check(rsp_valid == 0, "R3 idle no response", rsp_valid, 0);
    check_state("R3 idle");
  endtask

  initial begin
    bit [7:0] lfsr;
    do_reset();

    // Directed: fill set 0, evict, return to an evicted but recent block.
    access(8'h00);
    access(8'h10);
    access(8'h20);
    access(8'h05);
    idle();
    access(8'h18);
    access(8'h08);
    access(8'h0F);
    idle();
    idle();

    // Sweep every address in ascending order.
    for (int a = 0; a < 256; a++) access(a[7:0]);

    // Pseudo-random over a narrowed pool of blocks, with idle gaps.
    lfsr = 8'h5B;
    for (int n = 0; n < 800; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[0] && lfsr[6]) idle();
      else access({1'b0, lfsr[7:5] ^ lfsr[3:1], lfsr[4], lfsr[2:0]} & 8'h7F);
    end

    // Reset mid-run: earlier blocks become first references again.
    do_reset();
    access(8'h00);
    check(rsp_result == 2'b01, "R2 first access after reset", rsp_result, 1);

    check(class_cnt[0] > 0, "R4 hits observed", class_cnt[0], 1);
    check(class_cnt[1] > 0, "R7 first references observed", class_cnt[1], 1);
    check(class_cnt[2] > 0, "R8 conflicts observed", class_cnt[2], 1);
    check(class_cnt[3] > 0, "R9 capacity misses observed", class_cnt[3], 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule